// File: doc/BRIEF.md
# Prioritised Interrupt Router with Wake Request

The block gathers thirteen peripheral interrupt lines and feeds two CPU interrupt inputs. Each line is synchronised through two flops and then sensed in a way that is fixed per line: rising edge, falling edge (a single-clock low pulse), active-high level or active-low level. Edge and pulse events set a sticky pending bit that software clears by writing a one. Level lines show their live state and hold nothing.

Pending bits are gated by a per-line enable. The power-fail line alone drives the fast output `fiq_o`. Every other enabled pending line competes for the standard output `irq_o`. The winner is the line with the largest 4-bit priority value, and its index is presented on `win_idx_o`. While the CPU reports sleep, any enabled pending line raises `wake_o`. A small word-addressed register port holds the enables, the pending and clear word, the priorities and the winning index.

Source index map: 0 buzzer timer (rise), 1 OS tick timer (rise), 2 DSP interface (rise), 3 power fail (low level), 4 UART (high level), 5 keypad/GPIO (low pulse), 6 frame (rise), 7 page (rise), 8 GSM timer (rise), 9 timed serial port (rise), 10 SIM (high level), 11 fast UART (high level), 12 radio subsystem (rise).

Top module: `irq_router`

## Requirements
- R1: After reset all enables are 0, all priorities are 0, no bit is pending, `irq_o`, `fiq_o` and `wake_o` are low, and `win_idx_o` is 4'hF.
- R2: A rising-edge source (index 0, 1, 2, 6, 7, 8, 9 or 12) sets its pending bit once its synchronised line goes from 0 to 1, even for a one-cycle high pulse. The bit stays set until it is cleared. Holding the line high after a clear does not set it again.
- R3: The keypad source (index 5) idles high. A one-clock low pulse sets its sticky pending bit.
- R4: Level sources have no memory. Indices 4, 10 and 11 read pending while their line is 1, and index 3 reads pending while its line is 0.
- R5: Writing address 1 clears each sticky pending bit whose data bit is 1. Data bits of 0 leave pending bits unchanged. A new event in the same cycle wins over the clear.
- R6: Pending bits are visible at address 1 regardless of enable. A disabled source never drives `irq_o`, `fiq_o`, `wake_o` or `win_idx_o`.
- R7: Only source 3 drives `fiq_o`. It never appears on `irq_o` or `win_idx_o`.
- R8: Among enabled pending sources other than 3, the one with the largest priority value wins. On equal priority the lower index wins.
- R9: When no source other than 3 is enabled and pending, `irq_o` is low and `win_idx_o` is 4'hF.
- R10: `wake_o` is high exactly when `sleep_i` is high and at least one enabled source (source 3 included) is pending.
- R11: Register map (32-bit data, bit i = source i). Address 0 is the enable word. Address 1 reads the pending bits and clears them on write. Address 2 holds the priorities of sources 0 to 7 and address 3 those of sources 8 to 12, each priority at bits [4k+3:4k] with k = index mod 8. Address 4 reads the winning index in bits [3:0]. Bits without a field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 | Raw peripheral interrupt lines |
| sleep_i | input | 1 | CPU is in sleep mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| irq_o | output | 1 | Standard interrupt request |
| fiq_o | output | 1 | Fast interrupt request (power fail) |
| win_idx_o | output | 4 | Index of the winning standard source, 4'hF if none |
| wake_o | output | 1 | Wake request to the clock controller |

## Verification
The assertions check on every cycle that the idle index code matches a low `irq_o`, that source 3 is never the presented winner, that the winner is enabled, that wake follows sleep together with any active output, and that a sticky bit only falls when a clear names it. Only the bench scenarios can show the things that need a planned stimulus and a known expected answer: arbitration order including the equal-priority tie, that a single-clock pulse is caught on each edge kind, that a held line is not re-latched after a clear, that level sources hold nothing, and the field positions of the register map.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

  typedef enum logic [1:0] {
    SNS_RISE     = 2'd0,
    SNS_LVL_HI   = 2'd1,
    SNS_LVL_LO   = 2'd2,
    SNS_PULSE_LO = 2'd3
  } sense_e;

  // Fixed sensing per source index
  function automatic sense_e sense_of(input int idx);
    case (idx)
      3:          return SNS_LVL_LO;
      4, 10, 11:  return SNS_LVL_HI;
      5:          return SNS_PULSE_LO;
      default:    return SNS_RISE;
    endcase
  endfunction

  function automatic logic [31:0] sticky_mask();
    logic [31:0] m;
    for (int i = 0; i < 32; i++)
      m[i] = (sense_of(i) == SNS_RISE) || (sense_of(i) == SNS_PULSE_LO);
    return m;
  endfunction

endpackage

// File: rtl/irq_sense.sv
`timescale 1ns/1ps
module irq_sense
  import irq_router_pkg::*;
#(
  parameter sense_e SENSE = SNS_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);

  localparam logic IDLE = (SENSE == SNS_LVL_LO) || (SENSE == SNS_PULSE_LO);

  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
    end
  end

  if (SENSE == SNS_LVL_HI) begin : g_lvl_hi
    logic unused_clr;
    assign unused_clr = clr_i;
    assign pend_o = s2_q;
  end else if (SENSE == SNS_LVL_LO) begin : g_lvl_lo
    logic unused_clr;
    assign unused_clr = clr_i;
    assign pend_o = ~s2_q;
  end else begin : g_sticky
    logic prev_q, sticky_q, hit;
    assign hit = (SENSE == SNS_RISE) ? (s2_q & ~prev_q) : (prev_q & ~s2_q);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q   <= IDLE;
        sticky_q <= 1'b0;
      end else begin
        prev_q   <= s2_q;
        sticky_q <= (sticky_q & ~clr_i) | hit;  // new event wins over clear
      end
    end
    assign pend_o = sticky_q;
  end

endmodule

// File: rtl/irq_arb.sv
`timescale 1ns/1ps
module irq_arb #(
  parameter int N  = 13,
  parameter int PW = 4,
  parameter int IW = 4
) (
  input  logic [N-1:0]         act_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 valid_o,
  output logic [IW-1:0]        idx_o
);

  logic          found;
  logic [PW-1:0] best_p;
  logic [IW-1:0] best_i;

  // Strict compare keeps the lower index on a tie
  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '1;
    for (int i = 0; i < N; i++) begin
      if (act_i[i] && (!found || prio_i[i] > best_p)) begin
        found  = 1'b1;
        best_p = prio_i[i];
        best_i = IW'(i);
      end
    end
  end

  assign valid_o = found;
  assign idx_o   = best_i;

endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC   = 13,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int FIQ_SRC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              sleep_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic              wake_o
);

  localparam int PER_WORD = DATA_W / PRIO_W;
  localparam int N_PWORD  = (N_SRC + PER_WORD - 1) / PER_WORD;
  localparam int A_EN     = 0;
  localparam int A_PEND   = 1;
  localparam int A_PRIO   = 2;
  localparam int A_WIN    = A_PRIO + N_PWORD;
  localparam logic [N_SRC-1:0] FIQ_BIT = N_SRC'(1) << FIQ_SRC;

  logic [N_SRC-1:0]             en_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_SRC-1:0]             pend_w, clr_w, act_w;
  logic                         irq_valid;
  logic [IDX_W-1:0]             irq_idx;

  assign clr_w = (reg_we_i && int'(reg_addr_i) == A_PEND) ? reg_wdata_i[N_SRC-1:0] : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_sense #(.SENSE(sense_of(i))) u_sense (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (src_i[i]),
      .clr_i  (clr_w[i]),
      .pend_o (pend_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
    end else if (reg_we_i) begin
      if (int'(reg_addr_i) == A_EN) en_q <= reg_wdata_i[N_SRC-1:0];
      for (int i = 0; i < N_SRC; i++)
        if (int'(reg_addr_i) == A_PRIO + i / PER_WORD)
          prio_q[i] <= reg_wdata_i[(i % PER_WORD) * PRIO_W +: PRIO_W];
    end
  end

  assign act_w = pend_w & en_q;

  irq_arb #(.N(N_SRC), .PW(PRIO_W), .IW(IDX_W)) u_arb (
    .act_i   (act_w & ~FIQ_BIT),
    .prio_i  (prio_q),
    .valid_o (irq_valid),
    .idx_o   (irq_idx)
  );

  assign irq_o     = irq_valid;
  assign win_idx_o = irq_idx;
  assign fiq_o     = act_w[FIQ_SRC];
  assign wake_o    = sleep_i & (|act_w);

  always_comb begin
    reg_rdata_o = '0;
    if (int'(reg_addr_i) == A_EN)   reg_rdata_o[N_SRC-1:0] = en_q;
    if (int'(reg_addr_i) == A_PEND) reg_rdata_o[N_SRC-1:0] = pend_w;
    if (int'(reg_addr_i) == A_WIN)  reg_rdata_o[IDX_W-1:0] = irq_idx;
    for (int i = 0; i < N_SRC; i++)
      if (int'(reg_addr_i) == A_PRIO + i / PER_WORD)
        reg_rdata_o[(i % PER_WORD) * PRIO_W +: PRIO_W] = prio_q[i];
  end

endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int N_SRC   = 13,
  parameter int IDX_W   = 4,
  parameter int FIQ_SRC = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             wake_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] pend_w,
  input logic [N_SRC-1:0] clr_w
);

  localparam logic [31:0]      STICKY_ALL = sticky_mask();
  localparam logic [N_SRC-1:0] STICKY     = STICKY_ALL[N_SRC-1:0];

  a_r9_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (win_idx_o == '1));

  a_r7_fiq_not_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(win_idx_o) != FIQ_SRC);

  a_r6_winner_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int'(win_idx_o) < N_SRC && ((en_q >> win_idx_o) & N_SRC'(1)) != '0));

  a_r10_no_wake_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> !wake_o);

  a_r10_wake_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && (irq_o || fiq_o)) |-> wake_o);

  a_r5_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (($past(pend_w & ~clr_w) & STICKY & ~pend_w) == '0));

endmodule

bind irq_router irq_router_chk #(
  .N_SRC(N_SRC), .IDX_W(IDX_W), .FIQ_SRC(FIQ_SRC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .irq_o(irq_o),
  .fiq_o(fiq_o), .wake_o(wake_o), .win_idx_o(win_idx_o),
  .en_q(en_q), .pend_w(pend_w), .clr_w(clr_w)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src = 13'h0028;
  logic        slp = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, wake;
  logic [3:0]  idx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .sleep_i(slp),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .win_idx_o(idx), .wake_o(wake)
  );

  typedef struct packed {
    logic [12:0] src;
    logic [12:0] en;
    logic        slp;
    logic        irq;
    logic        fiq;
    logic        wk;
    logic [3:0]  idx;
  } vec_t;

  // Level lines only; bit 3 active low, bit 5 idles high
  localparam vec_t VECS [10] = '{
    '{13'h0028, 13'h1FFF, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF},
    '{13'h0038, 13'h1FFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'h4},
    '{13'h0438, 13'h1FFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'hA},
    '{13'h0C38, 13'h1FFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'hA},
    '{13'h0838, 13'h1FFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'hB},
    '{13'h0020, 13'h1FFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF},
    '{13'h0020, 13'h1FFF, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF},
    '{13'h0838, 13'h17FF, 1'b0, 1'b1, 1'b0, 1'b0, 4'h4},
    '{13'h0038, 13'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF},
    '{13'h0438, 13'h1FFF, 1'b1, 1'b1, 1'b0, 1'b1, 4'hA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIAL_GUARD");
    end
  endtask

  task automatic chk_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic done();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
        done();
      end
    end
  end

  initial begin
    logic [31:0] r;
    logic [12:0] pexp;

    cycles(3);
    // R1 reset state
    chk_val("R1 irq", {31'b0, irq}, 32'h0);
    chk_val("R1 fiq", {31'b0, fiq}, 32'h0);
    chk_val("R1 wake", {31'b0, wake}, 32'h0);
    chk_val("R1 idx", {28'b0, idx}, 32'hF);
    rst_n = 1'b1;
    cycles(4);
    rd(3'd0, r); chk_val("R1 enable", r, 32'h0);
    rd(3'd1, r); chk_val("R1 pending", r, 32'h0);
    rd(3'd2, r); chk_val("R1 prio lo", r, 32'h0);
    rd(3'd4, r); chk_val("R1 win reg", r, 32'hF);

    // R8 R11 priority setup: src4=2, src10=5, src11=5
    wr(3'd2, 32'h0002_0000);
    wr(3'd3, 32'h0000_5500);
    rd(3'd3, r); chk_val("R11 prio hi readback", r, 32'h0000_5500);

    // Vector table: R4 R6 R7 R8 R9 R10
    for (int v = 0; v < 10; v++) begin
      src = VECS[v].src;
      slp = VECS[v].slp;
      wr(3'd0, {19'b0, VECS[v].en});
      cycles(3);
      chk_val($sformatf("R8/R9 v%0d idx", v), {28'b0, idx}, {28'b0, VECS[v].idx});
      chk_val($sformatf("R9 v%0d irq", v), {31'b0, irq}, {31'b0, VECS[v].irq});
      chk_val($sformatf("R7 v%0d fiq", v), {31'b0, fiq}, {31'b0, VECS[v].fiq});
      chk_val($sformatf("R10 v%0d wake", v), {31'b0, wake}, {31'b0, VECS[v].wk});
      pexp = (VECS[v].src & 13'h0C10) | (~VECS[v].src & 13'h0008);
      rd(3'd1, r);
      chk_val($sformatf("R4/R6 v%0d pending", v), r, {19'b0, pexp});
    end
    src = 13'h0028; slp = 1'b0;
    wr(3'd0, 32'h0000_1FFF);
    cycles(3);
    rd(3'd1, r); chk_val("R4 level released", r, 32'h0);

    // R2 one-cycle pulses on src0 and src12, R8 priorities src0=3 src12=9
    wr(3'd2, 32'h0002_0003);
    wr(3'd3, 32'h0009_5500);
    rd(3'd3, r); chk_val("R11 prio hi field", r, 32'h0009_5500);
    @(negedge clk); src = 13'h1029;
    @(negedge clk); src = 13'h0028;
    cycles(4);
    rd(3'd1, r); chk_val("R2 sticky after pulse", r, 32'h0000_1001);
    chk_val("R8 higher prio wins", {28'b0, idx}, 32'hC);
    rd(3'd4, r); chk_val("R11 win reg", r, 32'hC);
    wr(3'd1, 32'h0000_1000);
    rd(3'd1, r); chk_val("R5 partial clear", r, 32'h0000_0001);
    chk_val("R8 next winner", {28'b0, idx}, 32'h0);
    wr(3'd1, 32'h0000_0000);
    rd(3'd1, r); chk_val("R5 zero write keeps", r, 32'h0000_0001);
    wr(3'd1, 32'h0000_0001);
    rd(3'd1, r); chk_val("R5 clear all", r, 32'h0);
    chk_val("R9 idle irq", {31'b0, irq}, 32'h0);
    chk_val("R9 idle idx", {28'b0, idx}, 32'hF);

    // R3 one-clock low pulse on keypad
    @(negedge clk); src = 13'h0008;
    @(negedge clk); src = 13'h0028;
    cycles(4);
    rd(3'd1, r); chk_val("R3 low pulse latched", r, 32'h0000_0020);
    chk_val("R3 winner", {28'b0, idx}, 32'h5);
    wr(3'd1, 32'h0000_0020);
    rd(3'd1, r); chk_val("R3 cleared", r, 32'h0);

    // R2 held line not re-latched after clear (DSP source)
    @(negedge clk); src = 13'h002C;
    cycles(4);
    rd(3'd1, r); chk_val("R2 rise latched", r, 32'h0000_0004);
    wr(3'd1, 32'h0000_0004);
    cycles(4);
    rd(3'd1, r); chk_val("R2 held high no relatch", r, 32'h0);
    chk_val("R2 no irq while held", {31'b0, irq}, 32'h0);
    src = 13'h0028;

    // R6 disabled edge source still shows pending, drives nothing
    wr(3'd0, 32'h0000_0000);
    slp = 1'b1;
    @(negedge clk); src = 13'h0029;
    @(negedge clk); src = 13'h0028;
    cycles(4);
    rd(3'd1, r); chk_val("R6 pending visible", r, 32'h0000_0001);
    chk_val("R6 no irq", {31'b0, irq}, 32'h0);
    chk_val("R6 no wake", {31'b0, wake}, 32'h0);
    wr(3'd0, 32'h0000_0001);
    cycles(1);
    chk_val("R10 wake on enable", {31'b0, wake}, 32'h1);
    slp = 1'b0;

    done();
  end

endmodule